// File: doc/BRIEF.md
# Chain Node with Scatter and Reduce

This block is one stage of a linear chain of identical processing stages. Each stage has a fixed position index `POS`, where 0 is the far end of the chain. A stage exchanges data with its neighbour on the input side and its neighbour on the output side. Each neighbour link carries traffic in both directions, and each direction has its own valid/ready pair.

The stage runs a fixed traffic pattern over and over with no end. First it relays `POS*PKT` words toward the far end. For each relayed word it accepts the word and then offers it on the output side. Next it takes `PKT` words that it keeps for itself and adds them into an accumulator. If `POS` is nonzero, it then accepts one partial result that comes back from the far side and adds that in too. It finishes the round by returning the accumulated sum, truncated to `DATA_W` bits, toward the input side. Any phase whose count is zero is skipped. A chain of such stages therefore scatters a block of data along the chain and reduces the partial sums back toward the head.

Top module: `chainNode`

## Requirements
- R1: After reset the node is at the start of a round with the accumulator at zero. With `POS*PKT>0`, `inReady` is 1 and `fwdValid`, `backReady` and `retValid` are 0.
- R2: In the relay phase the node relays exactly `POS*PKT` words in arrival order. It accepts one word on `inData`, then offers it unchanged on `fwdData`. It never accepts a new word while a relayed word is still being offered.
- R3: After relaying, the node accepts exactly `PKT` more words on the input link. These words are not forwarded.
- R4: When `POS` is nonzero, the node accepts one word on the back link (`backReady`) after the kept words. When `POS` is 0, `backReady` is never asserted.
- R5: Each round ends with exactly one word on `retData`. Its value is the sum of the kept words plus the back word (if one was read), modulo 2^`DATA_W`.
- R6: A phase whose count is zero is skipped entirely. With `POS=1` and `PKT=0`, the node waits on the back link straight after reset, with `inReady`=0.
- R7: All transfers block. An offered word (`fwdValid` or `retValid`) stays asserted with stable data until it is taken. Counts advance only on completed handshakes.
- R8: Rounds repeat without limit. The accumulator restarts from zero in each round.
- R9: At most one of `inReady`, `fwdValid`, `backReady` and `retValid` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inData | input | DATA_W | Word arriving from the input-side neighbour |
| inValid | input | 1 | inData is valid |
| inReady | output | 1 | Node accepts inData this cycle |
| retData | output | DATA_W | Result word returned to the input-side neighbour |
| retValid | output | 1 | retData is valid |
| retReady | input | 1 | Input-side neighbour takes retData |
| fwdData | output | DATA_W | Relayed word toward the output-side neighbour |
| fwdValid | output | 1 | fwdData is valid |
| fwdReady | input | 1 | Output-side neighbour takes fwdData |
| backData | input | DATA_W | Partial result coming back from the output side |
| backValid | input | 1 | backData is valid |
| backReady | output | 1 | Node accepts backData this cycle |

## Verification
The assertions check every cycle that at most one link handshake signal is active. They also check that offered words hold steady under backpressure, and that `backReady` stays low at position 0. At each returned result they confirm that the round moved exactly `POS*PKT` relayed words, `POS*PKT+PKT` input words and the right number of back words. Only the bench scenarios can show that relayed words keep their values and order, and that the returned sum is arithmetically correct, wrapping included. The bench covers three positions and packet sizes, including zero-count phases, over many rounds with varied stall lengths.

// File: rtl/chainNodePkg.sv
package chainNodePkg;

  typedef enum logic [2:0] {
    ST_FWD_RD,
    ST_FWD_WR,
    ST_KEEP,
    ST_GATHER,
    ST_REPLY
  } nodeState_e;

  typedef struct packed {
    logic loadHold;
    logic addIn;
    logic addBack;
    logic clearAcc;
  } nodeStrobes_t;

endpackage

// File: rtl/chainNodeDatapath.sv
module chainNodeDatapath
  import chainNodePkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nodeStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] backData,
  output logic [DATA_W-1:0] holdWord,
  output logic [DATA_W-1:0] accWord
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] accReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobes.loadHold) begin
      holdReg <= inData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
    end else if (strobes.clearAcc) begin
      accReg <= '0;
    end else if (strobes.addIn) begin
      accReg <= accReg + inData;
    end else if (strobes.addBack) begin
      accReg <= accReg + backData;
    end
  end

  assign holdWord = holdReg;
  assign accWord  = accReg;

endmodule

// File: rtl/chainNodeControl.sv
module chainNodeControl
  import chainNodePkg::*;
#(
  parameter int POS = 2,
  parameter int PKT = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         fwdReady,
  input  logic         backValid,
  input  logic         retReady,
  output logic         inReady,
  output logic         fwdValid,
  output logic         backReady,
  output logic         retValid,
  output nodeStrobes_t strobes
);

  localparam int FWD_CNT = POS * PKT;
  localparam int MAX_CNT = (FWD_CNT > PKT) ? FWD_CNT : PKT;
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  localparam nodeState_e AFTER_KEEP = (POS != 0) ? ST_GATHER : ST_REPLY;
  localparam nodeState_e AFTER_FWD  = (PKT > 0) ? ST_KEEP : AFTER_KEEP;
  localparam nodeState_e START_ST   = (FWD_CNT > 0) ? ST_FWD_RD : AFTER_FWD;

  nodeState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= START_ST;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    inReady   = 1'b0;
    fwdValid  = 1'b0;
    backReady = 1'b0;
    retValid  = 1'b0;
    strobes   = '0;
    unique case (state)
      ST_FWD_RD: begin
        inReady = 1'b1;
        if (inValid) begin
          strobes.loadHold = 1'b1;
          stateNext        = ST_FWD_WR;
        end
      end
      ST_FWD_WR: begin
        fwdValid = 1'b1;
        if (fwdReady) begin
          if (int'(cnt) == FWD_CNT - 1) begin
            cntNext   = '0;
            stateNext = AFTER_FWD;
          end else begin
            cntNext   = cnt + 1'b1;
            stateNext = ST_FWD_RD;
          end
        end
      end
      ST_KEEP: begin
        inReady = 1'b1;
        if (inValid) begin
          strobes.addIn = 1'b1;
          if (int'(cnt) == PKT - 1) begin
            cntNext   = '0;
            stateNext = AFTER_KEEP;
          end else begin
            cntNext = cnt + 1'b1;
          end
        end
      end
      ST_GATHER: begin
        backReady = 1'b1;
        if (backValid) begin
          strobes.addBack = 1'b1;
          stateNext       = ST_REPLY;
        end
      end
      ST_REPLY: begin
        retValid = 1'b1;
        if (retReady) begin
          strobes.clearAcc = 1'b1;
          stateNext        = START_ST;
        end
      end
      default: stateNext = START_ST;
    endcase
  end

endmodule

// File: rtl/chainNode.sv
module chainNode
  import chainNodePkg::*;
#(
  parameter int DATA_W = 8,
  parameter int POS    = 2,
  parameter int PKT    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic [DATA_W-1:0] retData,
  output logic              retValid,
  input  logic              retReady,
  output logic [DATA_W-1:0] fwdData,
  output logic              fwdValid,
  input  logic              fwdReady,
  input  logic [DATA_W-1:0] backData,
  input  logic              backValid,
  output logic              backReady
);

  nodeStrobes_t strobes;

  chainNodeControl #(.POS(POS), .PKT(PKT)) u_control (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .fwdReady  (fwdReady),
    .backValid (backValid),
    .retReady  (retReady),
    .inReady   (inReady),
    .fwdValid  (fwdValid),
    .backReady (backReady),
    .retValid  (retValid),
    .strobes   (strobes)
  );

  chainNodeDatapath #(.DATA_W(DATA_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inData   (inData),
    .backData (backData),
    .holdWord (fwdData),
    .accWord  (retData)
  );

endmodule

// File: rtl/chainNodeChecker.sv
module chainNodeChecker #(
  parameter int DATA_W = 8,
  parameter int POS    = 2,
  parameter int PKT    = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              fwdValid,
  input logic              fwdReady,
  input logic [DATA_W-1:0] fwdData,
  input logic              backValid,
  input logic              backReady,
  input logic              retValid,
  input logic              retReady,
  input logic [DATA_W-1:0] retData
);

  localparam int FWD_CNT = POS * PKT;

  int inSeen, fwdSeen, backSeen;
  logic retDone;

  assign retDone = retValid && retReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSeen   <= 0;
      fwdSeen  <= 0;
      backSeen <= 0;
    end else if (retDone) begin
      inSeen   <= 0;
      fwdSeen  <= 0;
      backSeen <= 0;
    end else begin
      if (inValid && inReady)     inSeen   <= inSeen + 1;
      if (fwdValid && fwdReady)   fwdSeen  <= fwdSeen + 1;
      if (backValid && backReady) backSeen <= backSeen + 1;
    end
  end

  assert_one_link_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inReady, fwdValid, backReady, retValid}));

  assert_fwd_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid && !fwdReady |=> fwdValid && $stable(fwdData));

  assert_ret_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    retValid && !retReady |=> retValid && $stable(retData));

  assert_no_gather_at_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    (POS == 0) |-> !backReady);

  assert_relay_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    retDone |-> fwdSeen == FWD_CNT);

  assert_keep_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    retDone |-> inSeen == FWD_CNT + PKT);

  assert_back_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    retDone |-> backSeen == ((POS != 0) ? 1 : 0));

  assert_relay_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    fwdSeen <= FWD_CNT);

endmodule

bind chainNode chainNodeChecker #(.DATA_W(DATA_W), .POS(POS), .PKT(PKT)) u_checker (.*);

// File: tb/test_chainNode.sv
module test_chainNode;

  localparam int W = 8;
  localparam int NI = 3;
  localparam int POS_OF [NI] = '{2, 0, 1};
  localparam int PKT_OF [NI] = '{3, 2, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] inData [NI];
  logic [W-1:0] backData [NI];
  logic [W-1:0] fwdData [NI];
  logic [W-1:0] retData [NI];
  logic inValid [NI], inReady [NI], retValid [NI], retReady [NI];
  logic fwdValid [NI], fwdReady [NI], backValid [NI], backReady [NI];

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  chainNode #(.DATA_W(W), .POS(2), .PKT(3)) i_chainNode (
    .clk(clk), .rstN(rstN),
    .inData(inData[0]), .inValid(inValid[0]), .inReady(inReady[0]),
    .retData(retData[0]), .retValid(retValid[0]), .retReady(retReady[0]),
    .fwdData(fwdData[0]), .fwdValid(fwdValid[0]), .fwdReady(fwdReady[0]),
    .backData(backData[0]), .backValid(backValid[0]), .backReady(backReady[0]));

  chainNode #(.DATA_W(W), .POS(0), .PKT(2)) i_chainNodeEnd (
    .clk(clk), .rstN(rstN),
    .inData(inData[1]), .inValid(inValid[1]), .inReady(inReady[1]),
    .retData(retData[1]), .retValid(retValid[1]), .retReady(retReady[1]),
    .fwdData(fwdData[1]), .fwdValid(fwdValid[1]), .fwdReady(fwdReady[1]),
    .backData(backData[1]), .backValid(backValid[1]), .backReady(backReady[1]));

  chainNode #(.DATA_W(W), .POS(1), .PKT(0)) i_chainNodeEmpty (
    .clk(clk), .rstN(rstN),
    .inData(inData[2]), .inValid(inValid[2]), .inReady(inReady[2]),
    .retData(retData[2]), .retValid(retValid[2]), .retReady(retReady[2]),
    .fwdData(fwdData[2]), .fwdValid(fwdValid[2]), .fwdReady(fwdReady[2]),
    .backData(backData[2]), .backValid(backValid[2]), .backReady(backReady[2]));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushIn(int i, logic [W-1:0] v);
    inValid[i] = 1'b1;
    inData[i]  = v;
    while (!inReady[i]) @(negedge clk);
    @(negedge clk);
    inValid[i] = 1'b0;
  endtask

  task automatic pushBack(int i, logic [W-1:0] v);
    backValid[i] = 1'b1;
    backData[i]  = v;
    while (!backReady[i]) @(negedge clk);
    @(negedge clk);
    backValid[i] = 1'b0;
  endtask

  // Waits for an offered relay word, holds off for 'stall' cycles, then takes it.
  task automatic pullFwd(int i, int exp, int stall);
    logic [W-1:0] first;
    while (!fwdValid[i]) @(negedge clk);
    check(inReady[i] == 1'b0, "R2 no read while relaying", int'(inReady[i]), 0);
    first = fwdData[i];
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(fwdValid[i] && fwdData[i] == first, "R7 relay held", int'(fwdData[i]), int'(first));
    end
    check(int'(fwdData[i]) == exp, "R2 relay value", int'(fwdData[i]), exp);
    fwdReady[i] = 1'b1;
    @(negedge clk);
    fwdReady[i] = 1'b0;
  endtask

  task automatic pullRet(int i, int exp, int stall);
    logic [W-1:0] first;
    while (!retValid[i]) begin
      if (POS_OF[i] == 0)
        check(backReady[i] == 1'b0, "R4 no back read at end", int'(backReady[i]), 0);
      @(negedge clk);
    end
    first = retData[i];
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(retValid[i] && retData[i] == first, "R7 result held", int'(retData[i]), int'(first));
    end
    check(int'(retData[i]) == exp, "R5 R8 result sum", int'(retData[i]), exp);
    retReady[i] = 1'b1;
    @(negedge clk);
    retReady[i] = 1'b0;
  endtask

  task automatic runRound(int i, int round);
    int sum = 0;
    int stall = round % 3;
    for (int k = 0; k < POS_OF[i] * PKT_OF[i]; k++) begin
      int v = (round * 37 + k * 11 + i * 5) & 8'hFF;
      pushIn(i, v[W-1:0]);
      pullFwd(i, v, stall);
    end
    for (int k = 0; k < PKT_OF[i]; k++) begin
      int v = (round * 91 + k * 53 + 200) & 8'hFF;  // large values force wrap (R5)
      pushIn(i, v[W-1:0]);
      sum += v;
    end
    if (POS_OF[i] != 0) begin
      int b = (round * 29 + 150) & 8'hFF;
      check(inReady[i] == 1'b0, "R3 R4 input closed during gather", int'(inReady[i]), 0);
      pushBack(i, b[W-1:0]);
      sum += b;
    end
    pullRet(i, sum & 8'hFF, stall);
  endtask

  initial begin
    for (int i = 0; i < NI; i++) begin
      inValid[i] = 0; inData[i] = '0; retReady[i] = 0; fwdReady[i] = 0;
      backValid[i] = 0; backData[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state of the main instance
    check(inReady[0] == 1'b1, "R1 inReady", int'(inReady[0]), 1);
    check(fwdValid[0] == 1'b0, "R1 fwdValid", int'(fwdValid[0]), 0);
    check(backReady[0] == 1'b0, "R1 backReady", int'(backReady[0]), 0);
    check(retValid[0] == 1'b0, "R1 retValid", int'(retValid[0]), 0);
    check(retData[0] == '0, "R1 accumulator", int'(retData[0]), 0);
    // R6 zero-count phases skipped
    check(backReady[2] == 1'b1, "R6 gather first", int'(backReady[2]), 1);
    check(inReady[2] == 1'b0, "R6 no input phase", int'(inReady[2]), 0);
    // R7 blocking: nothing advances while the partner is idle
    repeat (4) @(negedge clk);
    check(inReady[0] == 1'b1 && fwdValid[0] == 1'b0, "R7 stall waiting for input", int'(fwdValid[0]), 0);
    for (int i = 0; i < NI; i++)
      for (int r = 0; r < 8; r++)
        runRound(i, r);
    // R8 after the last round each node is back at its start
    check(inReady[0] == 1'b1, "R8 restart main", int'(inReady[0]), 1);
    check(inReady[1] == 1'b1, "R8 restart end node", int'(inReady[1]), 1);
    check(backReady[2] == 1'b1, "R8 restart empty node", int'(backReady[2]), 1);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule